// File: doc/BRIEF.md
# Binary-to-ASCII Digit Streamer with Unit Suffix

This block turns a binary frequency reading into text for a character display. A start strobe captures the binary value. A serial shift-and-add-3 converter then builds six decimal digits from it, consuming one input bit per clock. The block then hands the digits to the display one character at a time, most significant first, each as an ASCII code. A fixed three-character unit tag, "KHz", follows the digits.

Each character is offered with a valid strobe. It stays on the output until the display raises its ready input in a cycle where valid is high. A 3-bit select output tells the display which digit slot the current character belongs to. A one-cycle done pulse closes the message. Values too large for six digits are clamped to 999999 by default. The `SATURATE` parameter selects this variant.

Top module: `freq_digit_streamer`

## Requirements
- R1: While reset is asserted and in the first cycle after it, `char_valid`, `done`, `digit_sel` and `char_out` are all zero.
- R2: For every start, exactly nine characters are accepted: six decimal digits of the captured value, with leading zeros sent as the character '0', then the three unit characters.
- R3: A digit character is the ASCII code 0x30 plus the decimal digit value (range 0x30 to 0x39). Digits go out from the hundred-thousands place down to the units place.
- R4: While a digit is offered, `digit_sel` gives its slot: 0 for the most significant digit, rising to 5 for the least. While a unit character is offered, `digit_sel` is 7.
- R5: After the sixth digit, the unit characters are offered in the order 'K' (0x4B), 'H' (0x48), 'z' (0x7A).
- R6: A character moves on only in a cycle where `char_valid` and `disp_ready` are both high. While `disp_ready` is low, `char_valid`, `char_out` and `digit_sel` hold their values.
- R7: `done` is high for exactly one cycle: the cycle after the 'z' is accepted. `char_valid` is low while `done` is high.
- R8: A value above 999999 is streamed as 999999.
- R9: A start strobe is ignored while a conversion or message is in progress. No second message follows the one already running.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Capture `value_in` and begin when idle |
| value_in | input | IN_W | Binary value to display |
| disp_ready | input | 1 | Display accepts the offered character |
| char_out | output | 8 | ASCII character offered to the display |
| char_valid | output | 1 | `char_out` holds a character |
| digit_sel | output | 3 | Digit slot of the offered character, 7 for unit characters |
| done | output | 1 | One-cycle pulse after the last character is taken |

## Verification
The bench targets the following cases, and what a wrong design would do in each:
- Values with many digits equal to 5 or more, such as 999999 and 500500: a wrong adjust threshold in the converter shows up as wrong digits.
- The values 0 and 083333: these test leading zeros, which a design that drops or blanks them would not send.
- Values past the six-digit limit: without correct clamping, the top digits would come out as garbage.
- A display that stalls in varying patterns: a design that advances without ready would skip characters, and one that changes the character during a stall would corrupt the text.
- A start strobe during a message: a design that does not block it would restart mid-message or queue an extra message.

// File: rtl/fds_pkg.sv
package fds_pkg;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_CONV,
      ST_DIGIT,
      ST_UNIT,
      ST_FIN
   } fds_state_e;

   localparam logic [7:0] ASCII_ZERO = 8'h30;
   localparam logic [2:0] SEL_UNIT   = 3'd7;
   localparam int         UNIT_LEN   = 3;

   // unit tag characters, sent in index order
   function automatic logic [7:0] unit_char(input logic [1:0] idx);
      case (idx)
         2'd0:    return 8'h4B;
         2'd1:    return 8'h48;
         default: return 8'h7A;
      endcase
   endfunction

endpackage

// File: rtl/fds_nib_adj.sv
module fds_nib_adj (
   input  logic [3:0] din,
   output logic [3:0] dout
);
   always_comb begin
      if (din >= 4'd5) dout = din + 4'd3;
      else             dout = din;
   end
endmodule

// File: rtl/fds_dd_conv.sv
module fds_dd_conv #(
   parameter int IN_W     = 20,
   parameter int NDIG     = 6,
   parameter bit SATURATE = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load,
   input  logic [IN_W-1:0]   bin_in,
   output logic              busy,
   output logic              fin,
   output logic [4*NDIG-1:0] bcd_out
);
   localparam int BCD_W  = 4 * NDIG;
   localparam int WORK_W = BCD_W + IN_W;
   localparam int CNT_W  = $clog2(IN_W + 1);
   localparam logic [IN_W-1:0] MAX_VAL = IN_W'(10**NDIG - 1);

   logic [WORK_W-1:0] work;
   logic [CNT_W-1:0]  left;
   logic [BCD_W-1:0]  adj;
   logic [IN_W-1:0]   clamped;

   generate
      if (SATURATE) begin : g_sat
         assign clamped = (bin_in > MAX_VAL) ? MAX_VAL : bin_in;
      end else begin : g_raw
         assign clamped = bin_in;
      end
   endgenerate

   generate
      for (genvar g = 0; g < NDIG; g++) begin : g_nib
         fds_nib_adj u_adj (
            .din  (work[IN_W + 4*g +: 4]),
            .dout (adj[4*g +: 4])
         );
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         work <= '0;
         left <= '0;
         busy <= 1'b0;
         fin  <= 1'b0;
      end else if (load) begin
         work <= {{BCD_W{1'b0}}, clamped};
         left <= CNT_W'(IN_W);
         busy <= 1'b1;
         fin  <= 1'b0;
      end else if (busy) begin
         work <= {adj, work[IN_W-1:0]} << 1;
         left <= left - 1'b1;
         if (left == CNT_W'(1)) begin
            busy <= 1'b0;
            fin  <= 1'b1;
         end
      end else begin
         fin <= 1'b0;
      end
   end

   assign bcd_out = work[WORK_W-1 -: BCD_W];

endmodule

// File: rtl/fds_char_seq.sv
module fds_char_seq
   import fds_pkg::*;
#(
   parameter int NDIG = 6
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic              conv_fin,
   input  logic [4*NDIG-1:0] bcd,
   input  logic              disp_ready,
   output logic              load,
   output logic [7:0]        char_out,
   output logic              char_valid,
   output logic [2:0]        digit_sel,
   output logic              done
);
   localparam logic [2:0] LAST_DIG  = 3'(NDIG - 1);
   localparam logic [1:0] LAST_UNIT = 2'(UNIT_LEN - 1);

   fds_state_e state;
   logic [2:0] idx;
   logic [1:0] uidx;
   logic       accept;
   logic [3:0] nib;

   assign load   = (state == ST_IDLE) && start;
   assign accept = char_valid && disp_ready;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state <= ST_IDLE;
         idx   <= '0;
         uidx  <= '0;
      end else begin
         case (state)
            ST_IDLE: if (start) state <= ST_CONV;
            ST_CONV: if (conv_fin) begin
               state <= ST_DIGIT;
               idx   <= '0;
            end
            ST_DIGIT: if (accept) begin
               if (idx == LAST_DIG) begin
                  state <= ST_UNIT;
                  uidx  <= '0;
               end else begin
                  idx <= idx + 1'b1;
               end
            end
            ST_UNIT: if (accept) begin
               if (uidx == LAST_UNIT) state <= ST_FIN;
               else                   uidx  <= uidx + 1'b1;
            end
            default: state <= ST_IDLE;
         endcase
      end
   end

   always_comb begin
      nib = 4'(bcd >> (4 * (NDIG - 1 - int'(idx))));
      char_valid = 1'b0;
      char_out   = '0;
      digit_sel  = '0;
      case (state)
         ST_DIGIT: begin
            char_valid = 1'b1;
            char_out   = ASCII_ZERO + {4'b0, nib};
            digit_sel  = idx;
         end
         ST_UNIT: begin
            char_valid = 1'b1;
            char_out   = unit_char(uidx);
            digit_sel  = SEL_UNIT;
         end
         default: ;
      endcase
   end

   assign done = (state == ST_FIN);

endmodule

// File: rtl/freq_digit_streamer.sv
module freq_digit_streamer #(
   parameter int IN_W     = 20,
   parameter int NDIG     = 6,
   parameter bit SATURATE = 1'b1
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            start,
   input  logic [IN_W-1:0] value_in,
   input  logic            disp_ready,
   output logic [7:0]      char_out,
   output logic            char_valid,
   output logic [2:0]      digit_sel,
   output logic            done
);
   localparam int BCD_W = 4 * NDIG;

   generate
      if (NDIG < 1 || NDIG > 7) begin : g_bad_ndig
         $error("NDIG must lie in 1..7 so a digit slot fits beside the unit code");
      end
      if (IN_W < $clog2(10**NDIG) || IN_W > 30) begin : g_bad_inw
         $error("IN_W must hold the largest NDIG-digit value and stay within 30 bits");
      end
   endgenerate

   logic             load;
   logic             conv_busy;
   logic             conv_fin;
   logic [BCD_W-1:0] bcd;

   fds_dd_conv #(
      .IN_W     (IN_W),
      .NDIG     (NDIG),
      .SATURATE (SATURATE)
   ) u_conv (
      .clk     (clk),
      .rst_n   (rst_n),
      .load    (load),
      .bin_in  (value_in),
      .busy    (conv_busy),
      .fin     (conv_fin),
      .bcd_out (bcd)
   );

   fds_char_seq #(
      .NDIG (NDIG)
   ) u_seq (
      .clk        (clk),
      .rst_n      (rst_n),
      .start      (start),
      .conv_fin   (conv_fin),
      .bcd        (bcd),
      .disp_ready (disp_ready),
      .load       (load),
      .char_out   (char_out),
      .char_valid (char_valid),
      .digit_sel  (digit_sel),
      .done       (done)
   );

endmodule

// File: rtl/freq_digit_streamer_chk.sv
module freq_digit_streamer_chk (
   input logic       clk,
   input logic       rst_n,
   input logic       disp_ready,
   input logic [7:0] char_out,
   input logic       char_valid,
   input logic [2:0] digit_sel,
   input logic       done
);
   // R1
   reset_quiet_chk: assert property (@(posedge clk)
      !rst_n |=> (!char_valid && !done));

   // R3
   digit_ascii_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (char_valid && digit_sel != 3'd7) |-> (char_out >= 8'h30 && char_out <= 8'h39));

   // R4
   digit_slot_chk: assert property (@(posedge clk) disable iff (!rst_n)
      char_valid |-> (digit_sel <= 3'd5 || digit_sel == 3'd7));

   // R5
   unit_char_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (char_valid && digit_sel == 3'd7) |->
         (char_out == 8'h4B || char_out == 8'h48 || char_out == 8'h7A));

   // R6
   stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (char_valid && !disp_ready) |=>
         (char_valid && $stable(char_out) && $stable(digit_sel)));

   // R7
   done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);

   // R7
   done_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> !char_valid);

   // R7
   done_after_z_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(done) |-> $past(char_valid && disp_ready && char_out == 8'h7A));

endmodule

bind freq_digit_streamer freq_digit_streamer_chk u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .disp_ready (disp_ready),
   .char_out   (char_out),
   .char_valid (char_valid),
   .digit_sel  (digit_sel),
   .done       (done)
);

// File: tb/freq_digit_streamer_tb.sv
module freq_digit_streamer_tb;
   localparam int IN_W = 20;

   logic            clk = 1'b0;
   logic            rst_n;
   logic            start;
   logic [IN_W-1:0] value_in;
   logic            disp_ready;
   logic [7:0]      char_out;
   logic            char_valid;
   logic [2:0]      digit_sel;
   logic            done;

   int n_chk = 0;
   int n_bad = 0;

   always #10 clk = ~clk;

   freq_digit_streamer #(.IN_W(IN_W)) u_dut (
      .clk        (clk),
      .rst_n      (rst_n),
      .start      (start),
      .value_in   (value_in),
      .disp_ready (disp_ready),
      .char_out   (char_out),
      .char_valid (char_valid),
      .digit_sel  (digit_sel),
      .done       (done)
   );

   task automatic check_eq(input string req, input string what, input int act, input int exp);
      n_chk++;
      if (act != exp) begin
         n_bad++;
         $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
      end
   endtask

   task automatic finish_run();
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   endtask

   // R1: reset state
   task automatic test_reset();
      rst_n = 1'b0; start = 1'b0; value_in = '0; disp_ready = 1'b0;
      repeat (3) @(negedge clk);
      check_eq("R1", "char_valid in reset", int'(char_valid), 0);
      check_eq("R1", "done in reset", int'(done), 0);
      check_eq("R1", "digit_sel in reset", int'(digit_sel), 0);
      check_eq("R1", "char_out in reset", int'(char_out), 0);
      rst_n = 1'b1;
      @(negedge clk);
      check_eq("R1", "char_valid after reset", int'(char_valid), 0);
      check_eq("R1", "done after reset", int'(done), 0);
   endtask

   // rmode: 0 always ready, 1 every other cycle, 2 stall one cycle in five
   task automatic stream_case(input string req, input int v, input int rmode, input bit poke);
      int sv;
      logic [7:0] exp_c [9];
      int got;
      int cyc;
      bit stalled;
      logic [7:0] held_c;
      logic [2:0] held_s;
      int div;
      sv = (v > 999999) ? 999999 : v;
      div = 100000;
      for (int i = 0; i < 6; i++) begin
         exp_c[i] = 8'h30 + 8'((sv / div) % 10);
         div = div / 10;
      end
      exp_c[6] = 8'h4B; exp_c[7] = 8'h48; exp_c[8] = 8'h7A;

      @(negedge clk);
      start = 1'b1; value_in = IN_W'(v);
      @(negedge clk);
      start = 1'b0;
      got = 0; cyc = 0; stalled = 1'b0; held_c = '0; held_s = '0;
      while (got < 9 && cyc < 2000) begin
         if (stalled) begin
            check_eq("R6", "valid held in stall", int'(char_valid), 1);
            check_eq("R6", "char held in stall", int'(char_out), int'(held_c));
            check_eq("R6", "slot held in stall", int'(digit_sel), int'(held_s));
         end
         check_eq("R7", "done while streaming", int'(done), 0);
         case (rmode)
            0:       disp_ready = 1'b1;
            1:       disp_ready = cyc[0];
            default: disp_ready = (cyc % 5) != 0;
         endcase
         if (poke && (cyc % 7) == 3) begin
            start = 1'b1; value_in = IN_W'(123);
         end else begin
            start = 1'b0;
         end
         if (char_valid) begin
            if (disp_ready) begin
               if (got < 6)
                  check_eq(got == 0 ? "R3" : req, $sformatf("digit %0d of %0d", got, v),
                           int'(char_out), int'(exp_c[got]));
               else
                  check_eq("R5", $sformatf("unit char %0d", got - 6),
                           int'(char_out), int'(exp_c[got]));
               check_eq("R4", $sformatf("slot of char %0d", got),
                        int'(digit_sel), got < 6 ? got : 7);
               got++;
               stalled = 1'b0;
            end else begin
               stalled = 1'b1;
               held_c = char_out;
               held_s = digit_sel;
            end
         end else begin
            stalled = 1'b0;
         end
         @(negedge clk);
         cyc++;
      end
      disp_ready = 1'b0;
      start = 1'b0;
      check_eq("R2", "characters accepted", got, 9);
      check_eq("R7", "done after z", int'(done), 1);
      check_eq("R7", "valid low with done", int'(char_valid), 0);
      @(negedge clk);
      check_eq("R7", "done one cycle", int'(done), 0);
      if (poke) begin
         bit extra;
         extra = 1'b0;
         disp_ready = 1'b1;
         for (int k = 0; k < 60; k++) begin
            if (char_valid || done) extra = 1'b1;
            @(negedge clk);
         end
         disp_ready = 1'b0;
         check_eq("R9", "no message from start while busy", int'(extra), 0);
      end
   endtask

   initial begin
      test_reset();
      stream_case("R2", 123456, 0, 1'b0);
      stream_case("R2", 0, 1, 1'b0);
      stream_case("R3", 83333, 2, 1'b0);
      stream_case("R2", 100000, 0, 1'b0);
      stream_case("R3", 999999, 2, 1'b0);
      stream_case("R3", 500500, 1, 1'b0);
      stream_case("R8", 1000000, 0, 1'b0);
      stream_case("R8", (1 << IN_W) - 1, 2, 1'b0);
      stream_case("R9", 654321, 1, 1'b1);
      finish_run();
   end

   initial begin
      repeat (150000) @(posedge clk);
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_run();
   end

endmodule